// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a local-oscillator clock by a programmable ratio N and sends one narrow pulse per N input cycles to a phase comparator, which uses it as the comparison signal. The 16-bit ratio word has two fields. The lower four bits set a swallow count and the upper twelve bits set a main count. A dual-modulus prescaler divides by 17 while the swallow count is still running and by 16 after it expires. One full output cycle therefore spans 16 × main + swallow input cycles, which equals the ratio word.

Two oscillator clocks feed the block. A band-select input picks which one drives all of the counting logic. A mode input picks one of two ways to count. The pulse-swallow path uses the prescaler, the swallow counter and the main counter. The direct path uses a single 16-bit down-counter and gives the same ratio. The block samples the ratio word and the mode only at an output-cycle boundary, so a change made in the middle of a cycle never produces a short or long period. It raises ratio words below 528 to 528.

The control state machine has four states:

- `ST_IDLE`: the reset state. The first clock edge after reset is the load transition to a counting state.
- `ST_SWALLOW`: the prescaler divides by 17 and the swallow counter is nonzero. The swallow-expiry transition, on the prescaler wrap that takes the swallow count to zero, moves it to `ST_MAIN`.
- `ST_MAIN`: the prescaler divides by 16.
- `ST_DIRECT`: the plain down-counter runs.

The terminal transition is taken on the last input cycle of a period, from any counting state. It raises the output pulse and reloads. Its target state is:

- `ST_DIRECT` when the mode input is 0.
- `ST_SWALLOW` when the new swallow field is nonzero.
- `ST_MAIN` otherwise.

Top module: `psw_divider`

## Requirements
- R1: While reset is asserted and until the first output period completes, `fsig_pulse` is 0.
- R2: With `swallow_mode` = 1, the divide ratio is 16 × `ratio_word[15:4]` + `ratio_word[3:0]`, which equals the unsigned value of `ratio_word`.
- R3: The prescaler counts through 17 input cycles per step while the swallow count is nonzero, and 16 per step after that. This holds for every swallow value from 0 to 15.
- R4: `fsig_pulse` is high for exactly one selected-clock cycle, and consecutive rising edges of the pulse are exactly N selected-clock cycles apart.
- R5: A `ratio_word` value below 528, including 0, divides by exactly 528.
- R6: A change to `ratio_word` or `swallow_mode` during a period does not alter that period. The new value sets the length of the next period.
- R7: `band_sel` = 0 clocks the divider from `fm_clk`; `band_sel` = 1 clocks it from `am_clk`. When `band_sel` = 1, activity on `fm_clk` alone produces no pulse.
- R8: With `swallow_mode` = 0, the divider uses a single down-counter and gives the same ratio N as R2 and R5.
- R9: The first clock edge after reset release loads the ratio. The first pulse is registered on edge N+1 after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fm_clk | input | 1 | High-band oscillator clock |
| am_clk | input | 1 | Low-band oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| band_sel | input | 1 | 0 selects `fm_clk`, 1 selects `am_clk` |
| swallow_mode | input | 1 | 1 selects pulse-swallow counting, 0 selects direct counting |
| ratio_word | input | 16 | Divide ratio: bits [3:0] are the swallow count, bits [15:4] are the main count |
| fsig_pulse | output | 1 | One-cycle pulse, once per N selected-clock cycles |

## Verification
The bench builds the block with its default widths: a 4-bit swallow field, a 12-bit main field and a minimum ratio of 528. These defaults keep every period short enough to observe completely, from the clamped floor of 528 up to several thousand cycles. The largest swallow value of 15 sits on top of the smallest main count. This combination exercises the case where the swallow phase takes up nearly half of the main count. The two oscillator clocks run at unequal periods, and the bench can stop the low-band clock. This shows which clock actually advances the counters.

// File: rtl/psw_pkg.sv
package psw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2,
        ST_DIRECT  = 2'd3
    } psw_state_e;

endpackage

// File: rtl/psw_word_unit.sv
module psw_word_unit #(
    parameter int SW_W      = 4,
    parameter int MAIN_W    = 12,
    parameter int MIN_RATIO = 528,
    localparam int DIV_W    = SW_W + MAIN_W
) (
    input  logic [DIV_W-1:0]  word_in,
    output logic [DIV_W-1:0]  ratio_eff,
    output logic [MAIN_W-1:0] main_eff,
    output logic [SW_W-1:0]   swallow_eff
);

    localparam logic [DIV_W-1:0] MIN_VEC = DIV_W'(MIN_RATIO);

    generate
        if (MIN_RATIO > 0) begin : g_clamp
            always_comb begin
                if (word_in < MIN_VEC) ratio_eff = MIN_VEC;
                else                   ratio_eff = word_in;
            end
        end else begin : g_pass
            always_comb ratio_eff = word_in;
        end
    endgenerate

    always_comb begin
        main_eff    = ratio_eff[DIV_W-1:SW_W];
        swallow_eff = ratio_eff[SW_W-1:0];
    end

endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler #(
    parameter int SW_W     = 4,
    localparam int BASE    = 1 << SW_W,
    localparam int PC_W    = SW_W + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic mod_hi,
    output logic wrap
);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] last_v;

    always_comb begin
        last_v = mod_hi ? PC_W'(BASE) : PC_W'(BASE - 1);
        wrap   = run && (pc_q == last_v);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pc_q <= '0;
        else if (!run)    pc_q <= '0;
        else if (wrap)    pc_q <= '0;
        else              pc_q <= pc_q + 1'b1;
    end

    AST_PRE_LOW_MODULUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_hi) |-> (pc_q <= PC_W'(BASE - 1))) else $error("prescaler past low modulus"); // R3

    AST_PRE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (pc_q == '0)) else $error("prescaler moved while stopped"); // R8

endmodule

// File: rtl/psw_ctrl.sv
module psw_ctrl
    import psw_pkg::*;
#(
    parameter int SW_W      = 4,
    parameter int MAIN_W    = 12,
    parameter int MIN_RATIO = 528,
    localparam int DIV_W    = SW_W + MAIN_W,
    localparam int MIN_MAIN = MIN_RATIO >> SW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swallow_mode,
    input  logic [DIV_W-1:0]  ld_ratio,
    input  logic [MAIN_W-1:0] ld_main,
    input  logic [SW_W-1:0]   ld_swallow,
    input  logic              pre_wrap,
    output logic              pre_run,
    output logic              pre_mod_hi,
    output logic              pulse
);

    psw_state_e        state_q, state_d;
    logic [MAIN_W-1:0] main_q, main_d;
    logic [SW_W-1:0]   swl_q, swl_d;
    logic [DIV_W-1:0]  dcnt_q, dcnt_d;
    logic              terminal;
    logic              load;
    logic              pulse_q;

    always_comb begin
        pre_run    = (state_q == ST_SWALLOW) || (state_q == ST_MAIN);
        pre_mod_hi = (state_q == ST_SWALLOW);
        terminal   = ((state_q == ST_DIRECT) && (dcnt_q == '0)) ||
                     (pre_run && pre_wrap && (main_q == MAIN_W'(1)));
        load       = (state_q == ST_IDLE) || terminal;
    end

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        main_d  = main_q;
        swl_d   = swl_q;
        dcnt_d  = dcnt_q;
        if (load) begin
            main_d = ld_main;
            swl_d  = ld_swallow;
            dcnt_d = ld_ratio - 1'b1;
            if (!swallow_mode)            state_d = ST_DIRECT;
            else if (ld_swallow != '0)    state_d = ST_SWALLOW;
            else                          state_d = ST_MAIN;
        end else begin
            unique case (state_q)
                ST_SWALLOW: begin
                    if (pre_wrap) begin
                        main_d = main_q - 1'b1;
                        swl_d  = swl_q - 1'b1;
                        if (swl_q == SW_W'(1)) state_d = ST_MAIN;
                    end
                end
                ST_MAIN: begin
                    if (pre_wrap) main_d = main_q - 1'b1;
                end
                ST_DIRECT: begin
                    dcnt_d = dcnt_q - 1'b1;
                end
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_q <= '0;
            swl_q  <= '0;
            dcnt_q <= '0;
        end else begin
            main_q <= main_d;
            swl_q  <= swl_d;
            dcnt_q <= dcnt_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= terminal;
    end

    assign pulse = pulse_q;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q) else $error("pulse wider than one cycle"); // R4

    AST_NO_RETURN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_IDLE)) else $error("fell back to idle"); // R9

    AST_SWALLOW_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWALLOW) |-> (MAIN_W'(swl_q) <= main_q)) else $error("swallow exceeds main"); // R2

    AST_LOAD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (load && swallow_mode) |=> (main_q >= MAIN_W'(MIN_MAIN))) else $error("main below floor"); // R5

    AST_DIRECT_LOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIRECT) |-> (!pre_mod_hi && !pre_run)) else $error("prescaler active in direct"); // R8

    AST_MID_STABLE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MAIN && !terminal) |=> (state_q == ST_MAIN)) else $error("mode changed mid-period"); // R6

endmodule

// File: rtl/psw_divider.sv
module psw_divider
    import psw_pkg::*;
#(
    parameter int SW_W      = 4,
    parameter int MAIN_W    = 12,
    parameter int MIN_RATIO = 528,
    localparam int DIV_W    = SW_W + MAIN_W
) (
    input  logic             fm_clk,
    input  logic             am_clk,
    input  logic             rst_n,
    input  logic             band_sel,
    input  logic             swallow_mode,
    input  logic [DIV_W-1:0] ratio_word,
    output logic             fsig_pulse
);

    logic              vco_clk;
    logic [DIV_W-1:0]  ratio_eff;
    logic [MAIN_W-1:0] main_eff;
    logic [SW_W-1:0]   swallow_eff;
    logic              pre_run;
    logic              pre_mod_hi;
    logic              pre_wrap;

    assign vco_clk = band_sel ? am_clk : fm_clk;

    psw_word_unit #(.SW_W(SW_W), .MAIN_W(MAIN_W), .MIN_RATIO(MIN_RATIO)) u_word (
        .word_in     (ratio_word),
        .ratio_eff   (ratio_eff),
        .main_eff    (main_eff),
        .swallow_eff (swallow_eff)
    );

    psw_prescaler #(.SW_W(SW_W)) u_pre (
        .clk    (vco_clk),
        .rst_n  (rst_n),
        .run    (pre_run),
        .mod_hi (pre_mod_hi),
        .wrap   (pre_wrap)
    );

    psw_ctrl #(.SW_W(SW_W), .MAIN_W(MAIN_W), .MIN_RATIO(MIN_RATIO)) u_ctrl (
        .clk          (vco_clk),
        .rst_n        (rst_n),
        .swallow_mode (swallow_mode),
        .ld_ratio     (ratio_eff),
        .ld_main      (main_eff),
        .ld_swallow   (swallow_eff),
        .pre_wrap     (pre_wrap),
        .pre_run      (pre_run),
        .pre_mod_hi   (pre_mod_hi),
        .pulse        (fsig_pulse)
    );

endmodule

// File: tb/sim_psw_divider.sv
module sim_psw_divider;

    localparam int CLK_PERIOD = 10;
    localparam int AM_PERIOD  = 14;

    logic        fm_clk = 1'b0;
    logic        am_clk = 1'b0;
    logic        am_en  = 1'b1;
    logic        rst_n  = 1'b0;
    logic        band_sel = 1'b0;
    logic        swallow_mode = 1'b1;
    logic [15:0] ratio_word = 16'd1000;
    logic        fsig_pulse;
    logic        ref_clk;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    bit finished = 1'b0;

    psw_divider u0 (
        .fm_clk       (fm_clk),
        .am_clk       (am_clk),
        .rst_n        (rst_n),
        .band_sel     (band_sel),
        .swallow_mode (swallow_mode),
        .ratio_word   (ratio_word),
        .fsig_pulse   (fsig_pulse)
    );

    always #(CLK_PERIOD/2) fm_clk = ~fm_clk;
    always #(AM_PERIOD/2)  am_clk = am_en ? ~am_clk : 1'b0;

    assign ref_clk = band_sel ? am_clk : fm_clk;

    function automatic int eff_ratio(input logic [15:0] w);
        return (int'(w) < 528) ? 528 : int'(w);
    endfunction

    // behavioural reference: edges since reset, current period length
    bit model_idle = 1'b1;
    int model_cnt  = 0;
    int model_n    = 0;
    bit exp_pulse  = 1'b0;

    always @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            model_idle = 1'b1;
            model_cnt  = 0;
            exp_pulse  = 1'b0;
        end else if (model_idle) begin
            model_idle = 1'b0;
            model_n    = eff_ratio(ratio_word);
            model_cnt  = 0;
            exp_pulse  = 1'b0;
        end else begin
            model_cnt = model_cnt + 1;
            if (model_cnt == model_n) begin
                exp_pulse = 1'b1;
                model_cnt = 0;
                model_n   = eff_ratio(ratio_word);
            end else begin
                exp_pulse = 1'b0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge ref_clk) begin
        if (rst_n && !finished) check(cur_req, fsig_pulse, exp_pulse, "per-cycle pulse vs model");
    end

    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge ref_clk);
            n++;
        end while (!fsig_pulse);
    endtask

    task automatic restart(input logic band, input logic mode, input logic [15:0] w);
        rst_n = 1'b0;
        #(CLK_PERIOD * 3);
        band_sel = band;
        swallow_mode = mode;
        ratio_word = w;
        #(CLK_PERIOD * 3);
        @(negedge ref_clk);
        rst_n = 1'b1;
    endtask

    task automatic summary;
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        int n;
        int part;
        // R1: reset state
        #(CLK_PERIOD * 4);
        check("R1", fsig_pulse, 0, "pulse during reset");

        // R9, R2: first period and steady period, ratio 1000 = 62*16+8
        cur_req = "R2";
        restart(1'b0, 1'b1, 16'd1000);
        wait_pulse(n);
        check("R9", n, 1001, "edges to first pulse");
        wait_pulse(n);
        check("R2", n, 1000, "period for 1000");
        @(negedge ref_clk);
        check("R4", fsig_pulse, 0, "pulse one cycle wide");

        // R3: maximum swallow on top of minimum main count
        cur_req = "R3";
        ratio_word = 16'd543;
        wait_pulse(n);
        wait_pulse(n);
        check("R3", n, 543, "period for swallow 15");
        ratio_word = 16'h0C40;
        wait_pulse(n);
        wait_pulse(n);
        check("R3", n, 3136, "period for swallow 0");

        // R5: clamp
        cur_req = "R5";
        ratio_word = 16'd100;
        wait_pulse(n);
        wait_pulse(n);
        check("R5", n, 528, "period for word 100");
        ratio_word = 16'd0;
        wait_pulse(n);
        wait_pulse(n);
        check("R5", n, 528, "period for word 0");

        // R6: mid-period change
        cur_req = "R6";
        ratio_word = 16'd600;
        wait_pulse(n);
        wait_pulse(n);
        for (int i = 0; i < 100; i++) @(negedge ref_clk);
        ratio_word = 16'd900;
        swallow_mode = 1'b0;
        wait_pulse(part);
        check("R6", part + 100, 600, "period in flight keeps old word");
        wait_pulse(n);
        check("R6", n, 900, "next period uses new word");

        // R8: direct mode
        cur_req = "R8";
        ratio_word = 16'd777;
        wait_pulse(n);
        wait_pulse(n);
        check("R8", n, 777, "direct mode period");
        ratio_word = 16'd50;
        wait_pulse(n);
        wait_pulse(n);
        check("R8", n, 528, "direct mode clamp");
        swallow_mode = 1'b1;
        ratio_word = 16'd1234;
        wait_pulse(n);
        wait_pulse(n);
        check("R4", n, 1234, "back to swallow mode");

        // R7: low-band clock selected
        cur_req = "R7";
        restart(1'b1, 1'b1, 16'd700);
        wait_pulse(n);
        check("R7", n, 701, "first pulse on am_clk");
        wait_pulse(n);
        check("R7", n, 700, "period on am_clk");

        // R7: low-band selected but stopped; fm_clk must not count
        rst_n = 1'b0;
        am_en = 1'b0;
        ratio_word = 16'd528;
        #(CLK_PERIOD * 4);
        rst_n = 1'b1;
        n = 0;
        for (int i = 0; i < 1500; i++) begin
            @(negedge fm_clk);
            if (fsig_pulse) n++;
        end
        check("R7", n, 0, "no pulses from fm_clk when am selected");

        summary();
    end

endmodule